// File: doc/BRIEF.md
# Raster Position Interrupt Timer

This block keeps the beam position of a video frame: a dot counter that steps once per clock and a scanline counter that steps each time the dot counter wraps. Once per frame it announces the start of vertical blanking by setting a status flag and, when enabled, emitting a one-cycle non-maskable interrupt pulse. Independently it raises a level interrupt request at a programmed raster position. The request stays high until software reads the interrupt status register.

Software drives the block through a small register port. It holds a control register with three enables, two 9-bit compare values (each loaded as a low byte and a separate high bit), and two status registers that clear when read. The raster phase machine has two states. PH_ACTIVE moves to PH_VBLANK on the first dot of the blanking line. PH_VBLANK moves back to PH_ACTIVE when the frame wraps. The interrupt machine also has two states. IRQ_IDLE moves to IRQ_RAISED on a position hit. IRQ_RAISED moves back to IRQ_IDLE on a status read made in a cycle with no new hit.

Register addresses: 0 control, 1 horizontal compare low, 2 horizontal compare high, 3 vertical compare low, 4 vertical compare high, 5 blanking status, 6 interrupt status.

Top module: `raster_irq_timer`

## Requirements
- R1: The dot counter counts 0 to DOTS-1 and then returns to 0, advancing the scanline. The scanline counts 0 to LINES-1 and then returns to 0, and the frame counter increments in that same cycle.
- R2: In the control register (address 0), bit 7 enables the blanking NMI, bit 5 enables the vertical match and bit 4 enables the horizontal match. The other bits have no effect.
- R3: A write to address 1 (or 3) loads bits 7:0 of the horizontal (or vertical) compare. A write to address 2 (or 4) loads bit 8 of that compare from data bit 0. Each write leaves the other part of the compare unchanged.
- R4: After reset, both compares hold 0x1FF, all enables are off, the counters and frame count are 0, and both flags and both outputs are low.
- R5: With only the horizontal match enabled, irq_req rises in the cycle after the dot counter equals the horizontal compare, on every scanline.
- R6: With only the vertical match enabled, irq_req rises in the cycle after dot 0 of the scanline that equals the vertical compare.
- R7: With both matches enabled, irq_req rises in the cycle after the dot counter equals the horizontal compare on the scanline that equals the vertical compare.
- R8: A read of address 6 returns the interrupt flag in bit 7, with bits 6:0 zero, and drops irq_req after that clock edge. A hit in the same cycle as the read keeps the request set.
- R9: At dot 0 of scanline VB_LINE the blanking flag sets. nmi_pulse is high for exactly one cycle after that edge if bit 7 of the control register is set at that moment.
- R10: A read of address 5 returns the blanking flag in bit 7, with bits 6:0 zero, and clears the flag.
- R11: The blanking flag clears when the scanline counter wraps to 0.
- R12: Once raised, irq_req holds until read, even if the enables are turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one dot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status reads clear) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| nmi_pulse | output | 1 | One-cycle blanking interrupt pulse |
| irq_req | output | 1 | Level raster interrupt request |
| dot_pos | output | 9 | Current dot |
| line_pos | output | 9 | Current scanline |
| frame_cnt | output | FRAME_W | Frame counter |

## Verification
The assertions assume that reg_rd and reg_wr are never high together. They also assume DOTS is at least 2, so that a hit and the dot after it are distinct cycles, and that VB_LINE lies below LINES. The bench keeps to this. It issues each access as a single-cycle strobe from its own tasks and never overlaps a read with a write. It also elaborates the block with an 8-dot, 6-line frame, which keeps every compare value in range for the sweeps.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic {
        PH_ACTIVE,
        PH_VBLANK
    } phase_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_RAISED
    } irq_state_e;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_HCMP_L = 3'd1;
    localparam logic [ADDR_W-1:0] A_HCMP_H = 3'd2;
    localparam logic [ADDR_W-1:0] A_VCMP_L = 3'd3;
    localparam logic [ADDR_W-1:0] A_VCMP_H = 3'd4;
    localparam logic [ADDR_W-1:0] A_NMI_ST = 3'd5;
    localparam logic [ADDR_W-1:0] A_IRQ_ST = 3'd6;

    localparam int CTL_NMI_BIT  = 7;
    localparam int CTL_VIRQ_BIT = 5;
    localparam int CTL_HIRQ_BIT = 4;
    localparam int STAT_BIT     = 7;

endpackage

// File: rtl/raster_regs.sv
module raster_regs
    import raster_pkg::*;
#(
    parameter int CMP_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              nmi_en,
    output logic              v_en,
    output logic              h_en,
    output logic [CMP_W-1:0]  h_cmp,
    output logic [CMP_W-1:0]  v_cmp
);

    localparam int HI_W = CMP_W - DATA_W;

    logic unused_wbits;
    assign unused_wbits = ^{wdata[6], wdata[3:0], wdata[DATA_W-1:HI_W]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_en <= 1'b0;
            v_en   <= 1'b0;
            h_en   <= 1'b0;
            h_cmp  <= '1;
            v_cmp  <= '1;
        end else if (wr) begin
            unique case (addr)
                A_CTRL: begin
                    nmi_en <= wdata[CTL_NMI_BIT];
                    v_en   <= wdata[CTL_VIRQ_BIT];
                    h_en   <= wdata[CTL_HIRQ_BIT];
                end
                A_HCMP_L: h_cmp[DATA_W-1:0]     <= wdata;
                A_HCMP_H: h_cmp[CMP_W-1:DATA_W] <= wdata[HI_W-1:0];
                A_VCMP_L: v_cmp[DATA_W-1:0]     <= wdata;
                A_VCMP_H: v_cmp[CMP_W-1:DATA_W] <= wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/raster_counter.sv
module raster_counter
    import raster_pkg::*;
#(
    parameter int DOTS    = 341,
    parameter int LINES   = 262,
    parameter int VB_LINE = 225,
    parameter int CMP_W   = 9,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [CMP_W-1:0]   dot,
    output logic [CMP_W-1:0]   line,
    output logic [FRAME_W-1:0] frame,
    output logic               vb_enter,
    output logic               frame_wrap
);

    localparam logic [CMP_W-1:0] DOT_LAST  = CMP_W'(DOTS - 1);
    localparam logic [CMP_W-1:0] LINE_LAST = CMP_W'(LINES - 1);
    localparam logic [CMP_W-1:0] VB_POS    = CMP_W'(VB_LINE);

    phase_e phase, phase_nxt;
    logic   line_end;

    assign line_end   = (dot == DOT_LAST);
    assign frame_wrap = line_end && (line == LINE_LAST);
    assign vb_enter   = (phase == PH_ACTIVE) && (dot == '0) && (line == VB_POS);

    // Phase state register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_ACTIVE;
        else        phase <= phase_nxt;
    end

    // Phase transitions
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_ACTIVE: if (vb_enter)   phase_nxt = PH_VBLANK;
            PH_VBLANK: if (frame_wrap) phase_nxt = PH_ACTIVE;
            default:                   phase_nxt = PH_ACTIVE;
        endcase
    end

    // Position counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot   <= '0;
            line  <= '0;
            frame <= '0;
        end else if (frame_wrap) begin
            dot   <= '0;
            line  <= '0;
            frame <= frame + 1'b1;
        end else if (line_end) begin
            dot   <= '0;
            line  <= line + 1'b1;
        end else begin
            dot   <= dot + 1'b1;
        end
    end

endmodule

// File: rtl/raster_irq_logic.sv
module raster_irq_logic
    import raster_pkg::*;
#(
    parameter int CMP_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] dot,
    input  logic [CMP_W-1:0] line,
    input  logic [CMP_W-1:0] h_cmp,
    input  logic [CMP_W-1:0] v_cmp,
    input  logic             h_en,
    input  logic             v_en,
    input  logic             nmi_en,
    input  logic             vb_enter,
    input  logic             frame_wrap,
    input  logic             rd_nmi,
    input  logic             rd_irq,
    output logic             irq_hit,
    output logic             irq_req,
    output logic             vb_flag,
    output logic             nmi_pulse
);

    irq_state_e irq_st, irq_nxt;
    logic       h_match, v_match;

    assign h_match = (dot == h_cmp);
    assign v_match = (line == v_cmp);

    // Match condition depends on which enables are set
    always_comb begin
        unique case ({h_en, v_en})
            2'b10:   irq_hit = h_match;
            2'b01:   irq_hit = v_match && (dot == '0);
            2'b11:   irq_hit = h_match && v_match;
            default: irq_hit = 1'b0;
        endcase
    end

    // Interrupt state register
    always_ff @(posedge clk) begin
        if (!rst_n) irq_st <= IRQ_IDLE;
        else        irq_st <= irq_nxt;
    end

    // Interrupt transitions
    always_comb begin
        irq_nxt = irq_st;
        unique case (irq_st)
            IRQ_IDLE:   if (irq_hit)            irq_nxt = IRQ_RAISED;
            IRQ_RAISED: if (rd_irq && !irq_hit) irq_nxt = IRQ_IDLE;
            default:                            irq_nxt = IRQ_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_req = (irq_st == IRQ_RAISED);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb_flag   <= 1'b0;
            nmi_pulse <= 1'b0;
        end else begin
            nmi_pulse <= vb_enter && nmi_en;
            if (vb_enter)                 vb_flag <= 1'b1;
            else if (frame_wrap || rd_nmi) vb_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/raster_irq_timer.sv
module raster_irq_timer
    import raster_pkg::*;
#(
    parameter int DOTS    = 341,
    parameter int LINES   = 262,
    parameter int VB_LINE = 225,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [2:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               nmi_pulse,
    output logic               irq_req,
    output logic [8:0]         dot_pos,
    output logic [8:0]         line_pos,
    output logic [FRAME_W-1:0] frame_cnt
);

    localparam int CMP_W = 9;

    logic             nmi_en, v_en, h_en;
    logic [CMP_W-1:0] h_cmp, v_cmp;
    logic             vb_enter, frame_wrap;
    logic             rd_nmi, rd_irq;
    logic             irq_hit, vb_flag;

    assign rd_nmi = reg_rd && (reg_addr == A_NMI_ST);
    assign rd_irq = reg_rd && (reg_addr == A_IRQ_ST);

    raster_regs #(.CMP_W(CMP_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .nmi_en (nmi_en),
        .v_en   (v_en),
        .h_en   (h_en),
        .h_cmp  (h_cmp),
        .v_cmp  (v_cmp)
    );

    raster_counter #(
        .DOTS    (DOTS),
        .LINES   (LINES),
        .VB_LINE (VB_LINE),
        .CMP_W   (CMP_W),
        .FRAME_W (FRAME_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .dot        (dot_pos),
        .line       (line_pos),
        .frame      (frame_cnt),
        .vb_enter   (vb_enter),
        .frame_wrap (frame_wrap)
    );

    raster_irq_logic #(.CMP_W(CMP_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dot        (dot_pos),
        .line       (line_pos),
        .h_cmp      (h_cmp),
        .v_cmp      (v_cmp),
        .h_en       (h_en),
        .v_en       (v_en),
        .nmi_en     (nmi_en),
        .vb_enter   (vb_enter),
        .frame_wrap (frame_wrap),
        .rd_nmi     (rd_nmi),
        .rd_irq     (rd_irq),
        .irq_hit    (irq_hit),
        .irq_req    (irq_req),
        .vb_flag    (vb_flag),
        .nmi_pulse  (nmi_pulse)
    );

    // Status read mux
    always_comb begin
        reg_rdata = '0;
        if (rd_nmi) reg_rdata[STAT_BIT] = vb_flag;
        if (rd_irq) reg_rdata[STAT_BIT] = irq_req;
    end

endmodule

// File: rtl/raster_irq_timer_chk.sv
module raster_irq_timer_chk
    import raster_pkg::*;
#(
    parameter int DOTS    = 341,
    parameter int LINES   = 262,
    parameter int VB_LINE = 225,
    parameter int FRAME_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_rd,
    input logic [2:0]         reg_addr,
    input logic               irq_hit,
    input logic               irq_req,
    input logic               nmi_pulse,
    input logic [8:0]         dot_pos,
    input logic [8:0]         line_pos,
    input logic [FRAME_W-1:0] frame_cnt
);

    localparam logic [8:0] DOT_LAST  = 9'(DOTS - 1);
    localparam logic [8:0] LINE_LAST = 9'(LINES - 1);

    p_dot_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dot_pos <= DOT_LAST);

    p_dot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_pos != DOT_LAST) |=> (dot_pos == 9'($past(dot_pos) + 1'b1)));

    p_frame_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_pos == DOT_LAST && line_pos == LINE_LAST)
        |=> (line_pos == '0 && frame_cnt == FRAME_W'($past(frame_cnt) + 1'b1)));

    p_hit_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hit |=> irq_req);

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_IRQ_ST && !irq_hit) |=> !irq_req);

    p_irq_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !(reg_rd && reg_addr == A_IRQ_ST)) |=> irq_req);

    p_nmi_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |=> !nmi_pulse);

    p_nmi_place_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_pulse |-> (line_pos == 9'(VB_LINE) && dot_pos == 9'd1));

endmodule

bind raster_irq_timer raster_irq_timer_chk #(
    .DOTS    (DOTS),
    .LINES   (LINES),
    .VB_LINE (VB_LINE),
    .FRAME_W (FRAME_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .irq_hit   (irq_hit),
    .irq_req   (irq_req),
    .nmi_pulse (nmi_pulse),
    .dot_pos   (dot_pos),
    .line_pos  (line_pos),
    .frame_cnt (frame_cnt)
);

// File: tb/sim_raster_irq_timer.sv
module sim_raster_irq_timer;

    localparam int D  = 8;
    localparam int L  = 6;
    localparam int VB = 4;
    localparam int FW = 8;
    localparam int FRAME = D * L;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          nmi_pulse, irq_req;
    logic [8:0]    dot_pos, line_pos;
    logic [FW-1:0] frame_cnt;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    raster_irq_timer #(.DOTS(D), .LINES(L), .VB_LINE(VB), .FRAME_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nmi_pulse(nmi_pulse), .irq_req(irq_req), .dot_pos(dot_pos),
        .line_pos(line_pos), .frame_cnt(frame_cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(input int limit, output bit got);
        got = 1'b0;
        for (int i = 0; i < limit; i++) begin
            if (irq_req) begin got = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // Disable, load compares, enable, then clear any stale request
    task automatic arm(input logic [7:0] ctl, input int h, input int v);
        logic [7:0] d;
        wr(3'd0, 8'h00);
        wr(3'd1, 8'(h)); wr(3'd2, 8'(h >> 8));
        wr(3'd3, 8'(v)); wr(3'd4, 8'(v >> 8));
        wr(3'd0, ctl);
        rd(3'd6, d);
    endtask

    task automatic clear_check(input string req);
        logic [7:0] d;
        rd(3'd6, d);
        check(d == 8'h80, req, int'(d), 128);
        check(irq_req == 1'b0, req, int'(irq_req), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        bit got;
        int l1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R4: reset state
        check(irq_req == 0 && nmi_pulse == 0, "R4 outputs", int'(irq_req), 0);

        // R1: counter sweep over two frames plus a few dots
        for (int k = 0; k < 2 * FRAME + 5; k++) begin
            check(dot_pos == 9'(k % D), "R1 dot", int'(dot_pos), k % D);
            check(line_pos == 9'((k / D) % L), "R1 line", int'(line_pos), (k / D) % L);
            check(frame_cnt == FW'(k / FRAME), "R1 frame", int'(frame_cnt), k / FRAME);
            @(negedge clk);
        end

        // R4: compares reset to 0x1FF, out of range here
        wr(3'd0, 8'h10); rd(3'd6, d);
        wait_irq(FRAME + 4, got);
        check(!got, "R4 hcmp reset", int'(got), 0);
        wr(3'd0, 8'h20); rd(3'd6, d);
        wait_irq(FRAME + 4, got);
        check(!got, "R4 vcmp reset", int'(got), 0);

        // R2: unrelated control bits do nothing
        arm(8'h4F, 2, 2);
        for (int i = 0; i < FRAME + 4; i++) begin
            if (irq_req || nmi_pulse) got = 1'b1;
            @(negedge clk);
        end
        check(!got, "R2 other bits", int'(got), 0);

        // R5: horizontal only, every compare value
        for (int h = 0; h < D; h++) begin
            arm(8'h10, h, 0);
            wait_irq(FRAME + 4, got);
            check(got, "R5 fires", int'(got), 1);
            check(dot_pos == 9'((h + 1) % D), "R5 dot", int'(dot_pos), (h + 1) % D);
            l1 = int'(line_pos);
            clear_check("R8 h read");
            wait_irq(D + 4, got);
            check(got && line_pos == 9'((l1 + 1) % L), "R5 next line", int'(line_pos), (l1 + 1) % L);
            rd(3'd6, d);
        end

        // R6: vertical only, every line
        for (int v = 0; v < L; v++) begin
            arm(8'h20, 0, v);
            wait_irq(FRAME + 4, got);
            check(got && line_pos == 9'(v) && dot_pos == 9'd1, "R6 position",
                  int'(line_pos) * 16 + int'(dot_pos), v * 16 + 1);
            clear_check("R8 v read");
        end

        // R7: both enabled
        for (int v = 0; v < L; v++) begin
            for (int hi = 0; hi < 3; hi++) begin
                int h;
                h = (hi == 0) ? 0 : (hi == 1) ? 3 : D - 1;
                arm(8'h30, h, v);
                wait_irq(FRAME + 4, got);
                check(got && dot_pos == 9'((h + 1) % D), "R7 dot", int'(dot_pos), (h + 1) % D);
                check(line_pos == 9'((h == D - 1) ? (v + 1) % L : v), "R7 line",
                      int'(line_pos), (h == D - 1) ? (v + 1) % L : v);
                rd(3'd6, d);
            end
        end

        // R3: high-bit and low-byte writes are independent
        arm(8'h10, 3, 0);
        wr(3'd2, 8'h01); rd(3'd6, d);
        wait_irq(FRAME + 4, got);
        check(!got, "R3 h bit8 set", int'(got), 0);
        wr(3'd2, 8'hFE); rd(3'd6, d);
        wait_irq(FRAME + 4, got);
        check(got && dot_pos == 9'd4, "R3 h low kept", int'(dot_pos), 4);
        arm(8'h20, 0, 2);
        wr(3'd4, 8'h01); rd(3'd6, d);
        wait_irq(FRAME + 4, got);
        check(!got, "R3 v bit8 set", int'(got), 0);
        wr(3'd4, 8'h00); rd(3'd6, d);
        wait_irq(FRAME + 4, got);
        check(got && line_pos == 9'd2, "R3 v low kept", int'(line_pos), 2);

        // R12: request holds after enables drop
        wr(3'd0, 8'h00);
        repeat (FRAME) @(negedge clk);
        check(irq_req == 1'b1, "R12 hold", int'(irq_req), 1);
        clear_check("R8 after hold");

        // R9/R10: NMI enabled
        wr(3'd0, 8'h80);
        got = 1'b0;
        for (int i = 0; i < FRAME + 4; i++) begin
            if (nmi_pulse) begin got = 1'b1; break; end
            @(negedge clk);
        end
        check(got && line_pos == 9'(VB) && dot_pos == 9'd1, "R9 pulse place",
              int'(line_pos) * 16 + int'(dot_pos), VB * 16 + 1);
        @(negedge clk);
        check(nmi_pulse == 1'b0, "R9 one cycle", int'(nmi_pulse), 0);
        rd(3'd5, d);
        check(d == 8'h80, "R10 flag read", int'(d), 128);
        rd(3'd5, d);
        check(d == 8'h00, "R10 cleared", int'(d), 0);

        // R9: NMI disabled, flag still sets
        wr(3'd0, 8'h00);
        while (!(line_pos == 9'(VB) && dot_pos == 9'd2)) begin
            if (nmi_pulse) got = 1'b0;
            @(negedge clk);
        end
        check(got, "R9 no pulse when off", int'(!got), 0);
        rd(3'd5, d);
        check(d == 8'h80, "R9 flag sets", int'(d), 128);

        // R11: flag cleared by frame wrap
        while (!(line_pos == 9'(VB) && dot_pos == 9'd2)) @(negedge clk);
        while (line_pos != 9'd0) @(negedge clk);
        rd(3'd5, d);
        check(d == 8'h00, "R11 wrap clear", int'(d), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule